// File: doc/BRIEF.md
# Address Breakpoint Match Table

This block keeps a small, densely packed list of breakpoint entries. Each entry holds an address and a short type code. A debug controller fills the list with add commands and removes entries with clear commands. The execution side presents its current program counter every cycle and gets back, with no clock delay, the type of the first entry that carries that address.

Entries always occupy slots 0 to count-1, in the order they were added. A clear removes only the lowest slot whose address and type both equal the request. Every later entry then moves down one slot in the same clock, so the list stays dense and keeps its order. The block is never busy: a new command can be accepted every cycle.

Top module: `bkpt_match_table`

## Requirements
- R1: After reset, `cnt_o` is 0, `ovf_o` is 0, `clr_done_o` and `clr_ok_o` are 0, and no lookup hits.
- R2: An add (`add_i`=1, `clr_i`=0) with count below capacity stores `cmd_addr_i` and `cmd_type_i` in slot `count`, and `cnt_o` rises by one after the clock edge.
- R3: An add while `cnt_o` equals capacity leaves the table and count unchanged and sets `ovf_o`. `ovf_o` stays at 1 until reset.
- R4: A clear removes only the lowest-index entry whose address and type both equal `cmd_addr_i` and `cmd_type_i`. An entry that matches on address alone is never removed.
- R5: A successful clear shifts every entry above the removed slot down by one slot, keeping their order, and decrements `cnt_o`. In the cycle after the command, `clr_done_o`=1 and `clr_ok_o`=1.
- R6: A clear that matches no entry leaves the table and count unchanged. In the cycle after the command, `clr_done_o`=1 and `clr_ok_o`=0.
- R7: Lookup compares `pc_i` with entry addresses only. Through combinational logic it drives `hit_o`=1 and the type of the lowest-index matching entry on `hit_type_o`. With no match it drives `hit_o`=0 and `hit_type_o`=0.
- R8: A slot at index greater than or equal to `cnt_o` never matches a lookup, including a slot that a clear has just vacated.
- R9: If `add_i` and `clr_i` are both 1 in the same cycle, only the clear is performed and the add is dropped without setting `ovf_o`. A lookup in the same cycle as any command sees the table as it was before that command.
- R10: `clr_done_o` and `clr_ok_o` are one-cycle pulses, 0 in any cycle that does not follow a clear command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| add_i | input | 1 | Add command strobe |
| clr_i | input | 1 | Clear command strobe |
| cmd_addr_i | input | ADDR_W | Address operand for add and clear |
| cmd_type_i | input | TYPE_W | Type operand for add and clear |
| pc_i | input | ADDR_W | Program counter presented for lookup |
| hit_o | output | 1 | A valid entry carries address `pc_i` |
| hit_type_o | output | TYPE_W | Type of the first matching entry, 0 if there is none |
| clr_done_o | output | 1 | Pulse: a clear was processed in the previous cycle |
| clr_ok_o | output | 1 | Pulse: that clear removed an entry |
| cnt_o | output | $clog2(DEPTH+1) | Number of valid entries |
| ovf_o | output | 1 | Sticky flag: an add was refused because the table was full |

## Verification
Two pairs of functions can fall in the same cycle. The first is a lookup alongside a clear. The bench drives a clear and a `pc_i` matching the entry being removed in the same cycle, and samples `hit_type_o` before the edge. It must return the old first-match type. After the edge, the same lookup must return the type of the next entry with that address, which has now moved down. The second is an add together with a clear. The bench asserts both strobes at once on a full table and judges the result by the count falling by one, the cleared address no longer matching, and `ovf_o` keeping its earlier value.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int unsigned BK_ADDR_W = 32;
    localparam int unsigned BK_TYPE_W = 3;
    localparam int unsigned BK_DEPTH  = 8;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_ADD  = 2'd1,
        BK_CLR  = 2'd2,
        BK_BOTH = 2'd3
    } bk_op_e;
endpackage

// File: rtl/bkpt_cmp.sv
// Per-slot comparator: a lookup hit needs an address match, a clear hit needs address and type.
module bkpt_cmp #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TYPE_W = 3
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] ent_addr_i,
    input  logic [TYPE_W-1:0] ent_type_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [TYPE_W-1:0] req_type_i,
    output logic              pc_hit_o,
    output logic              clr_hit_o
);
    always_comb begin
        pc_hit_o  = valid_i && (ent_addr_i == pc_i);
        clr_hit_o = valid_i && (ent_addr_i == req_addr_i) && (ent_type_i == req_type_i);
    end
endmodule

// File: rtl/bkpt_prio.sv
// Lowest-index-first finder over a request vector.
module bkpt_prio #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/bkpt_match_table.sv
module bkpt_match_table
    import bkpt_pkg::*;
#(
    parameter int unsigned DEPTH  = BK_DEPTH,
    parameter int unsigned ADDR_W = BK_ADDR_W,
    parameter int unsigned TYPE_W = BK_TYPE_W,
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [TYPE_W-1:0] cmd_type_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              hit_o,
    output logic [TYPE_W-1:0] hit_type_o,
    output logic              clr_done_o,
    output logic              clr_ok_o,
    output logic [CW-1:0]     cnt_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][TYPE_W-1:0] typ;
        logic [CW-1:0]                cnt;
        logic                         ovf;
        logic                         done;
        logic                         ok;
    } state_t;

    state_t state_d, state_q;

    logic [DEPTH-1:0] valid;
    logic [DEPTH-1:0] pc_hit;
    logic [DEPTH-1:0] clr_hit;
    logic             pc_found;
    logic [IW-1:0]    pc_idx;
    logic             clr_found;
    logic [IW-1:0]    clr_idx;

    // Occupancy mask and per-slot comparators
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign valid[g] = (CW'(g) < state_q.cnt);

        bkpt_cmp #(
            .ADDR_W(ADDR_W),
            .TYPE_W(TYPE_W)
        ) u_cmp (
            .valid_i    (valid[g]),
            .ent_addr_i (state_q.addr[g]),
            .ent_type_i (state_q.typ[g]),
            .pc_i       (pc_i),
            .req_addr_i (cmd_addr_i),
            .req_type_i (cmd_type_i),
            .pc_hit_o   (pc_hit[g]),
            .clr_hit_o  (clr_hit[g])
        );
    end

    bkpt_prio #(.N(DEPTH)) u_pc_prio (
        .req_i   (pc_hit),
        .found_o (pc_found),
        .idx_o   (pc_idx)
    );

    bkpt_prio #(.N(DEPTH)) u_clr_prio (
        .req_i   (clr_hit),
        .found_o (clr_found),
        .idx_o   (clr_idx)
    );

    // Next-state computation
    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        state_d.ok   = 1'b0;
        if (clr_i) begin
            state_d.done = 1'b1;
            if (clr_found) begin
                state_d.ok  = 1'b1;
                state_d.cnt = state_q.cnt - 1'b1;
                for (int i = 0; i < DEPTH; i++) begin
                    if (IW'(i) >= clr_idx) begin
                        if (i < DEPTH - 1) begin
                            state_d.addr[i] = state_q.addr[i+1];
                            state_d.typ[i]  = state_q.typ[i+1];
                        end else begin
                            state_d.addr[i] = '0;
                            state_d.typ[i]  = '0;
                        end
                    end
                end
            end
        end else if (add_i) begin
            if (state_q.cnt == CW'(DEPTH)) begin
                state_d.ovf = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == state_q.cnt) begin
                        state_d.addr[i] = cmd_addr_i;
                        state_d.typ[i]  = cmd_type_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        hit_o      = pc_found;
        hit_type_o = pc_found ? state_q.typ[pc_idx] : '0;
        clr_done_o = state_q.done;
        clr_ok_o   = state_q.ok;
        cnt_o      = state_q.cnt;
        ovf_o      = state_q.ovf;
    end
endmodule

// File: rtl/bkpt_match_table_chk.sv
module bkpt_match_table_chk #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned TYPE_W = 3,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              add_i,
    input logic              clr_i,
    input logic              hit_o,
    input logic [TYPE_W-1:0] hit_type_o,
    input logic              clr_done_o,
    input logic              clr_ok_o,
    input logic [CW-1:0]     cnt_o,
    input logic              ovf_o
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CW'(DEPTH)); // R3

    AST_ADD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !clr_i && cnt_o != CW'(DEPTH)) |=> (cnt_o == CW'($past(cnt_o) + 1'b1))); // R2

    AST_FULL_ADD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !clr_i && cnt_o == CW'(DEPTH)) |=> (ovf_o && cnt_o == CW'(DEPTH))); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R3

    AST_CLR_OK_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done_o && clr_ok_o) |-> (cnt_o == CW'($past(cnt_o) - 1'b1))); // R5

    AST_CLR_MISS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done_o && !clr_ok_o) |-> $stable(cnt_o)); // R6

    AST_DONE_FOLLOWS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> clr_done_o); // R10

    AST_OK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok_o |-> clr_done_o); // R10

    AST_BOTH_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && clr_i && !ovf_o) |=> !ovf_o); // R9

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0) |-> (!hit_o && hit_type_o == '0)); // R8

    AST_MISS_ZERO_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (hit_type_o == '0)); // R7
endmodule

bind bkpt_match_table bkpt_match_table_chk #(
    .DEPTH  (DEPTH),
    .TYPE_W (TYPE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .add_i      (add_i),
    .clr_i      (clr_i),
    .hit_o      (hit_o),
    .hit_type_o (hit_type_o),
    .clr_done_o (clr_done_o),
    .clr_ok_o   (clr_ok_o),
    .cnt_o      (cnt_o),
    .ovf_o      (ovf_o)
);

// File: tb/bkpt_match_table_bench.sv
`timescale 1ns/1ps
module bkpt_match_table_bench;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned AW    = 32;
    localparam int unsigned TW    = 3;
    localparam int unsigned CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          add_i = 1'b0;
    logic          clr_i = 1'b0;
    logic [AW-1:0] cmd_addr_i = '0;
    logic [TW-1:0] cmd_type_i = '0;
    logic [AW-1:0] pc_i = '0;
    logic          hit_o;
    logic [TW-1:0] hit_type_o;
    logic          clr_done_o;
    logic          clr_ok_o;
    logic [CW-1:0] cnt_o;
    logic          ovf_o;

    int errors = 0;
    int checks = 0;
    bit reported = 1'b0;

    always #2.5 clk = ~clk;

    bkpt_match_table #(.DEPTH(DEPTH), .ADDR_W(AW), .TYPE_W(TW)) u_bkpt_match_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .add_i      (add_i),
        .clr_i      (clr_i),
        .cmd_addr_i (cmd_addr_i),
        .cmd_type_i (cmd_type_i),
        .pc_i       (pc_i),
        .hit_o      (hit_o),
        .hit_type_o (hit_type_o),
        .clr_done_o (clr_done_o),
        .clr_ok_o   (clr_ok_o),
        .cnt_o      (cnt_o),
        .ovf_o      (ovf_o)
    );

    // op: 0 idle, 1 add, 2 clear, 3 both strobes
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [2:0]  typ;
        logic [31:0] pc;
        logic [3:0]  cnt;
        logic        done;
        logic        ok;
        logic        hit;
        logic [2:0]  htype;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 32'h1000, 3'd1, 32'h1000, 4'd1, 1'b0, 1'b0, 1'b1, 3'd1},
        '{2'd1, 32'h2000, 3'd2, 32'h2000, 4'd2, 1'b0, 1'b0, 1'b1, 3'd2},
        '{2'd1, 32'h1000, 3'd3, 32'h1000, 4'd3, 1'b0, 1'b0, 1'b1, 3'd1},
        '{2'd2, 32'h1000, 3'd3, 32'h1000, 4'd2, 1'b1, 1'b1, 1'b1, 3'd1},
        '{2'd2, 32'h2000, 3'd5, 32'h2000, 4'd2, 1'b1, 1'b0, 1'b1, 3'd2},
        '{2'd1, 32'h3000, 3'd4, 32'h3000, 4'd3, 1'b0, 1'b0, 1'b1, 3'd4},
        '{2'd2, 32'h1000, 3'd1, 32'h1000, 4'd2, 1'b1, 1'b1, 1'b0, 3'd0},
        '{2'd0, 32'h0000, 3'd0, 32'h2000, 4'd2, 1'b0, 1'b0, 1'b1, 3'd2},
        '{2'd2, 32'h3000, 3'd4, 32'h3000, 4'd1, 1'b1, 1'b1, 1'b0, 3'd0},
        '{2'd1, 32'h4000, 3'd0, 32'h4000, 4'd2, 1'b0, 1'b0, 1'b1, 3'd0},
        '{2'd1, 32'h1000, 3'd6, 32'h1000, 4'd3, 1'b0, 1'b0, 1'b1, 3'd6},
        '{2'd1, 32'h2000, 3'd7, 32'h2000, 4'd4, 1'b0, 1'b0, 1'b1, 3'd2},
        '{2'd1, 32'h3000, 3'd5, 32'h3000, 4'd4, 1'b0, 1'b0, 1'b0, 3'd0},
        '{2'd3, 32'h4000, 3'd0, 32'h4000, 4'd3, 1'b1, 1'b1, 1'b0, 3'd0}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Drive a command at the falling edge, let one rising edge take it, then idle the strobes.
    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [2:0] t);
        @(negedge clk);
        add_i      = op[0];
        clr_i      = op[1];
        cmd_addr_i = a;
        cmd_type_i = t;
        @(posedge clk);
        @(negedge clk);
        add_i = 1'b0;
        clr_i = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        pc_i = 32'h1000;
        #1;
        check("R1 count after reset", 32'(cnt_o), 0);
        check("R1 ovf after reset", 32'(ovf_o), 0);
        check("R1 done after reset", 32'(clr_done_o), 0);
        check("R1 ok after reset", 32'(clr_ok_o), 0);
        check("R1 no hit after reset", 32'(hit_o), 0);
        rst_n = 1'b1;

        // Vector table
        for (int k = 0; k < NV; k++) begin
            issue(VEC[k].op, VEC[k].addr, VEC[k].typ);
            pc_i = VEC[k].pc;
            #1;
            check($sformatf("R2 R3 R5 R6 R9 count v%0d", k), 32'(cnt_o), 32'(VEC[k].cnt));
            check($sformatf("R5 R6 R10 done v%0d", k), 32'(clr_done_o), 32'(VEC[k].done));
            check($sformatf("R4 R5 R6 ok v%0d", k), 32'(clr_ok_o), 32'(VEC[k].ok));
            check($sformatf("R7 R8 hit v%0d", k), 32'(hit_o), 32'(VEC[k].hit));
            check($sformatf("R7 type v%0d", k), 32'(hit_type_o), 32'(VEC[k].htype));
            if (k == 12) check("R3 ovf set on full add", 32'(ovf_o), 1);
        end
        // Table now: 0x2000/2, 0x1000/6, 0x2000/7

        check("R3 ovf sticky after combined command", 32'(ovf_o), 1);

        // R9: lookup in the cycle of a clear sees the old table
        @(negedge clk);
        clr_i      = 1'b1;
        cmd_addr_i = 32'h2000;
        cmd_type_i = 3'd2;
        pc_i       = 32'h2000;
        #1;
        check("R9 same-cycle lookup type", 32'(hit_type_o), 2);
        @(posedge clk);
        @(negedge clk);
        clr_i = 1'b0;
        #1;
        check("R5 later entry shifted down, lookup type", 32'(hit_type_o), 7);
        check("R5 count after clear", 32'(cnt_o), 2);
        check("R10 done pulse present", 32'(clr_done_o), 1);
        @(negedge clk);
        #1;
        check("R10 done pulse gone", 32'(clr_done_o), 0);
        check("R10 ok pulse gone", 32'(clr_ok_o), 0);
        pc_i = 32'h1000;
        #1;
        check("R5 order kept, first slot type", 32'(hit_type_o), 6);

        // R4: address-only match must not be removed
        issue(2'd2, 32'h1000, 3'd7);
        pc_i = 32'h1000;
        #1;
        check("R4 address-only clear fails", 32'(clr_ok_o), 0);
        check("R4 entry still present", 32'(hit_type_o), 6);

        // Reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 count after second reset", 32'(cnt_o), 0);
        check("R1 ovf cleared by reset", 32'(ovf_o), 0);
        check("R8 no hit on cleared table", 32'(hit_o), 0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule